// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block feeds an external serial-in, parallel-out shift register that drives up to 17 LEDs or general-purpose outputs. It produces a serial data line, a shift clock and a one-cycle store pulse for expanders that have an output latch. A small register interface lets software set the shift clock rate, the spacing between a data change and the following clock edge, and the operating mode.

In direct mode, software writes a 17-bit word and the block shifts it out at once. While the shift runs, a busy flag is set, and software must wait for it to clear. In PWM mode, the serial bits come from the 17 generator outputs of a neighbouring PWM bank. The block shifts only when that vector differs from the last word it sent. Entering PWM mode resets that reference to zero, so software must first clear the expander by shifting out zeros in direct mode.

The clock rate and delay settings are captured when a shift starts. Changing them later takes effect from the next shift.

Top module: `sled_shift_ctrl`

## Requirements
- R1: After reset, `sclk`, `sdata` and `strobe` are low. All four registers read 0, including the busy flag.
- R2: In direct mode and while idle, a write to address 0 starts a shift of bits 16:0.
  - The bits go out most significant first, one bit per rising edge of `sclk`, with exactly 17 rising edges.
  - Address 0 then reads back the word in bits 16:0.
- R3: The busy flag is bit 31 of address 0.
  - It reads 1 from the cycle after a shift starts, for exactly 17 × div cycles.
  - A write to address 0 while busy is ignored.
- R4: Address 1 bits 1:0 hold the divider code c, which sets div = 4 << c clock cycles per bit (code 3 gives 32).
  - Rising edges of `sclk` are div cycles apart, and each high phase lasts div/2 cycles.
  - `sclk` is low when idle.
- R5: Address 2 bits 3:0 hold the delay v.
  - Each data bit appears on `sdata` v+1 cycles before its rising edge of `sclk`.
  - A value above div/2 − 1 acts as div/2 − 1.
  - `sdata` does not change while `sclk` is high.
- R6: Address 3 bit 1 selects PWM mode.
  - Switching it on resets the reference word to 0.
  - No shift starts while the generator vector equals the reference.
  - When the vector differs and the block is idle, a shift of the vector starts at the next edge, and the vector becomes the new reference.
- R7: A write to address 3 while busy is ignored.
- R8: Each shift ends with a one-cycle `strobe` pulse in the cycle where busy clears. When address 3 bit 0 is set (mode for clock-only expanders without a latch), no pulse is produced.
- R9: In PWM mode, writes to address 0 are ignored.
- R10: If the generator vector changes during a PWM shift, a new shift carrying the latest vector starts so that busy is low for exactly one cycle between the two shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address, used for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| gen_bits | input | 17 | Generator outputs from the PWM bank |
| sclk | output | 1 | Shift clock to the expander |
| sdata | output | 1 | Serial data to the expander |
| strobe | output | 1 | Store pulse after the last bit |

## Verification
A wrong bit counter or wrong slot counter shows up within a single shift. It appears as the wrong number of `sclk` rising edges, the wrong edge spacing, or a busy window that does not equal 17 × div cycles. A wrong shadowed delay, or a wrong clamp, shifts the first rising edge away from v+2 cycles after busy rises. A stale PWM reference word shows up either as a shift that starts when it should not, or as a missing shift within one cycle of the generator change. Gating faults appear at the next read of address 0 or 3 after a write made while busy.

// File: rtl/sled_pkg.sv
package sled_pkg;
  typedef enum logic [1:0] {
    REG_WORD   = 2'd0,
    REG_CLKDIV = 2'd1,
    REG_DELAY  = 2'd2,
    REG_MODE   = 2'd3
  } sled_reg_e;

  localparam int MODE_COMPAT_BIT = 0;
  localparam int MODE_PWM_BIT    = 1;
  localparam int MODE_W          = 2;
endpackage

// File: rtl/sled_regs.sv
module sled_regs
  import sled_pkg::*;
#(
  parameter int NBITS    = 17,
  parameter int DIVW     = 2,
  parameter int DLYW     = 4,
  parameter int DW       = 32,
  parameter int BUSY_BIT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NBITS-1:0] gen_i,
  input  logic             busy_i,
  output logic             start_o,
  output logic [NBITS-1:0] word_o,
  output logic [DIVW-1:0]  div_code_o,
  output logic [DLYW-1:0]  delay_o,
  output logic             compat_o
);
  logic [NBITS-1:0]  word_q;
  logic [DIVW-1:0]   div_q;
  logic [DLYW-1:0]   dly_q;
  logic [MODE_W-1:0] mode_q;
  logic              pwm_on, dir_start, pwm_start;

  assign pwm_on    = mode_q[MODE_PWM_BIT];
  assign dir_start = wr_en && (addr == REG_WORD) && !busy_i && !pwm_on;
  assign pwm_start = pwm_on && !busy_i && (gen_i != word_q);
  assign start_o   = dir_start || pwm_start;
  assign word_o    = dir_start ? wdata[NBITS-1:0] : gen_i;
  assign div_code_o = div_q;
  assign delay_o    = dly_q;
  assign compat_o   = mode_q[MODE_COMPAT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      div_q  <= '0;
      dly_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          REG_WORD:   if (dir_start) word_q <= wdata[NBITS-1:0];
          REG_CLKDIV: div_q <= wdata[DIVW-1:0];
          REG_DELAY:  dly_q <= wdata[DLYW-1:0];
          REG_MODE: begin
            if (!busy_i) begin
              mode_q <= wdata[MODE_W-1:0];
              if (wdata[MODE_PWM_BIT] && !pwm_on) word_q <= '0;
            end
          end
          default: ;
        endcase
      end
      if (pwm_start) word_q <= gen_i;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_WORD: begin
        rdata[NBITS-1:0] = word_q;
        rdata[BUSY_BIT]  = busy_i;
      end
      REG_CLKDIV: rdata[DIVW-1:0]   = div_q;
      REG_DELAY:  rdata[DLYW-1:0]   = dly_q;
      REG_MODE:   rdata[MODE_W-1:0] = mode_q;
      default: ;
    endcase
  end

  // R3: a data write during a shift leaves the word untouched
  assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_WORD && busy_i) |=> $stable(word_q));
  // R7: a mode write during a shift leaves the mode untouched
  assert_mode_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_MODE && busy_i) |=> $stable(mode_q));
  // R3: every start is taken by the engine
  assert_start_taken_R3: assert property (@(posedge clk) disable iff (rst)
    start_o |=> busy_i);
endmodule

// File: rtl/sled_engine.sv
module sled_engine #(
  parameter int NBITS = 17,
  parameter int DIVW  = 2,
  parameter int DLYW  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NBITS-1:0] word_i,
  input  logic [DIVW-1:0]  div_code_i,
  input  logic [DLYW-1:0]  delay_i,
  input  logic             compat_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             strobe_o
);
  localparam int MAXDIV = 4 << ((1 << DIVW) - 1);
  localparam int CNTW   = $clog2(MAXDIV);
  localparam int BIDXW  = $clog2(NBITS);
  localparam int WW     = ((CNTW > DLYW) ? CNTW : DLYW) + 1;

  logic [CNTW-1:0]  half_n, half_s, lead_s, cnt_q;
  logic [WW-1:0]    cap_w, dly_w, lead_w;
  logic [CNTW:0]    cnt_x, rise_pt, fall_pt, last_pt;
  logic [BIDXW-1:0] bidx_q;
  logic [NBITS-1:0] sh_q;
  logic             busy_q, sclk_q, sdata_q, strobe_q, compat_s;

  assign half_n = CNTW'(2) << div_code_i;
  assign cap_w  = WW'(half_n) - WW'(1);
  assign dly_w  = WW'(delay_i);
  assign lead_w = ((dly_w > cap_w) ? cap_w : dly_w) + WW'(1);

  assign cnt_x   = {1'b0, cnt_q};
  assign rise_pt = {1'b0, lead_s};
  assign fall_pt = rise_pt + {1'b0, half_s};
  assign last_pt = {half_s, 1'b0} - {{CNTW{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      sdata_q  <= 1'b0;
      strobe_q <= 1'b0;
      compat_s <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
      bidx_q   <= '0;
      half_s   <= '0;
      lead_s   <= '0;
    end else begin
      strobe_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= 1'b0;
        if (start_i) begin
          busy_q   <= 1'b1;
          sh_q     <= word_i;
          cnt_q    <= '0;
          bidx_q   <= '0;
          half_s   <= half_n;
          lead_s   <= CNTW'(lead_w);
          compat_s <= compat_i;
        end
      end else begin
        if (cnt_q == '0) begin
          sdata_q <= sh_q[NBITS-1];
          sh_q    <= sh_q << 1;
        end
        sclk_q <= (cnt_x >= rise_pt) && (cnt_x < fall_pt);
        if (cnt_x == last_pt) begin
          cnt_q <= '0;
          if (bidx_q == BIDXW'(NBITS - 1)) begin
            busy_q   <= 1'b0;
            strobe_q <= !compat_s;
          end else begin
            bidx_q <= bidx_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign sdata_o  = sdata_q;
  assign strobe_o = strobe_q;

  always_comb begin
    if (!rst) begin
      assert_bit_index_R2: assert (int'(bidx_q) < NBITS);
    end
  end
  // R4: shift clock stays low once idle
  assert_sclk_rests_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q)) |-> !sclk_o);
  // R5: data is held while the expander may sample
  assert_data_held_high_R5: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> $stable(sdata_o));
  // R8: store pulse only at the end of a shift
  assert_strobe_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $fell(busy_o));
endmodule

// File: rtl/sled_shift_ctrl.sv
module sled_shift_ctrl #(
  parameter int NBITS    = 17,
  parameter int DIVW     = 2,
  parameter int DLYW     = 4,
  parameter int DW       = 32,
  parameter int BUSY_BIT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NBITS-1:0] gen_bits,
  output logic             sclk,
  output logic             sdata,
  output logic             strobe
);
  logic             busy, start, compat;
  logic [NBITS-1:0] word;
  logic [DIVW-1:0]  div_code;
  logic [DLYW-1:0]  delay;

  sled_regs #(.NBITS(NBITS), .DIVW(DIVW), .DLYW(DLYW), .DW(DW), .BUSY_BIT(BUSY_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .gen_i(gen_bits), .busy_i(busy), .start_o(start), .word_o(word),
    .div_code_o(div_code), .delay_o(delay), .compat_o(compat)
  );

  sled_engine #(.NBITS(NBITS), .DIVW(DIVW), .DLYW(DLYW)) u_engine (
    .clk(clk), .rst(rst), .start_i(start), .word_i(word), .div_code_i(div_code),
    .delay_i(delay), .compat_i(compat), .busy_o(busy), .sclk_o(sclk),
    .sdata_o(sdata), .strobe_o(strobe)
  );
endmodule

// File: tb/sled_shift_ctrl_test.sv
module sled_shift_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 17;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [NB-1:0] gen_bits = 0;
  logic sclk, sdata, strobe;
  int nvec = 0, nbad = 0;
  logic restarted;

  sled_shift_ctrl uut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gen_bits(gen_bits), .sclk(sclk), .sdata(sdata), .strobe(strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_div(int c); return 4 << c; endfunction
  function automatic int f_veff(int v, int c);
    int h = 2 << c;
    return (v > h - 1) ? h - 1 : v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    tick(); addr = a; wdata = d; wr_en = 1;
    tick(); wr_en = 0; addr = 2'd0; #1;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 2'd0; #1;
  endtask

  // Samples a shift starting at idx 0 (first cycle busy is visible).
  task automatic capture(logic [NB-1:0] exp, int c, int v, bit compat, string tag);
    int idx = 0, nrise = 0, first = -1, last = -1, hi = 0, pbad = 0, hbad = 0, nstb = 0;
    int div = f_div(c), h = 2 << c;
    logic prev = 0;
    logic [NB-1:0] got = 0;
    restarted = 0;
    addr = 2'd0; #1;
    while (rdata[31] === 1'b1 && idx < 2000) begin
      if (sclk && !prev) begin
        got = {got[NB-2:0], sdata};
        if (nrise == 0) first = idx; else if (idx - last != div) pbad++;
        last = idx; nrise++; hi = 0;
      end
      if (sclk) hi++; else if (prev && hi != h) hbad++;
      if (strobe) nstb++;
      prev = sclk; tick(); idx++;
    end
    chk({tag, " R3 busy span"}, idx, NB * div);
    for (int k = 0; k < 2; k++) begin
      if (rdata[31] === 1'b1) begin restarted = 1; break; end
      if (strobe) nstb++;
      if (!sclk && prev && hi != h) hbad++;
      if (sclk) hi++;
      prev = sclk;
      if (k == 0) tick();
    end
    if (!restarted) begin
      tick();
      chk({tag, " R4 idle low"}, sclk, 0);
      if (rdata[31] === 1'b1) restarted = 1;
    end
    chk({tag, " R2 word"}, got, exp);
    chk({tag, " R2 rises"}, nrise, NB);
    chk({tag, " R4 period"}, pbad, 0);
    chk({tag, " R4 high width"}, hbad, 0);
    chk({tag, " R5 lead"}, first, v + 2);
    chk({tag, " R8 strobe"}, nstb, compat ? 0 : 1);
  endtask

  initial begin
    tick(); tick();
    nbad++;
    #(CLK_PERIOD * 200000);
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NB-1:0] w, w2;
    nbad = 0;
    void'($urandom(32'h5eed));
    repeat (3) tick();
    rst = 0;
    nbad = 0;
    tick();
    // R1 reset state
    chk("R1 sclk", sclk, 0); chk("R1 sdata", sdata, 0); chk("R1 strobe", strobe, 0);
    for (int a = 0; a < 4; a++) begin reg_read(a[1:0], d); chk("R1 reg", d, 0); end

    // R2/R4/R5 directed
    reg_write(2'd2, 0);
    reg_write(2'd0, 32'h1a5a5);
    capture(17'h1a5a5, 0, 0, 0, "dir0");
    reg_read(2'd0, d); chk("R2 readback", d, 32'h1a5a5);
    reg_write(2'd2, 5);
    reg_write(2'd0, 32'h10001);
    capture(17'h10001, 0, f_veff(5, 0), 0, "R5 clamp");
    reg_write(2'd1, 3); reg_write(2'd2, 15);
    reg_write(2'd0, 32'h0ffff);
    capture(17'h0ffff, 3, 15, 0, "div32");

    // R3 / R7: writes while busy
    reg_write(2'd1, 1); reg_write(2'd2, 2);
    reg_write(2'd0, 32'h0c3c3);
    repeat (10) tick();
    reg_write(2'd0, 32'h13579);
    reg_read(2'd0, d); chk("R3 write ignored", d[NB-1:0], 17'h0c3c3);
    reg_write(2'd3, 2);
    reg_read(2'd3, d); chk("R7 mode ignored", d, 0);
    while (rdata[31] === 1'b1) tick();
    repeat (5) tick();
    chk("R3 no second shift", rdata[31], 0);

    // R8 compat mode
    reg_write(2'd3, 1); reg_write(2'd1, 0); reg_write(2'd2, 1);
    reg_write(2'd0, 32'h00000);
    capture(17'h0, 0, 1, 1, "R8 compat");

    // R6 PWM
    reg_write(2'd3, 2);
    reg_read(2'd0, d); chk("R6 ref cleared", d, 0);
    repeat (40) tick();
    chk("R6 lazy idle", rdata[31], 0);
    gen_bits = 17'h00801; tick();
    capture(17'h00801, 0, 1, 0, "R6 pwm");
    reg_read(2'd0, d); chk("R6 ref updated", d, 32'h00801);
    // R9
    reg_write(2'd0, 32'h1ffff);
    reg_read(2'd0, d); chk("R9 data write in pwm", d, 32'h00801);
    // R10
    gen_bits = 17'h1f00f; tick();
    fork
      capture(17'h1f00f, 0, 1, 0, "R10 first");
      begin repeat (20) tick(); gen_bits = 17'h0aaaa; end
    join
    chk("R10 restart", restarted, 1);
    capture(17'h0aaaa, 0, 1, 0, "R10 second");
    gen_bits = 0; tick();
    capture(17'h0, 0, 1, 0, "R6 back to zero");

    // random direct shifts
    reg_write(2'd3, 0);
    for (int i = 0; i < 25; i++) begin
      int c = $urandom % 3, v = $urandom % 16;
      bit cm = 1'($urandom % 2);
      w = NB'($urandom);
      reg_write(2'd1, c); reg_write(2'd2, v); reg_write(2'd3, {31'b0, cm});
      reg_write(2'd0, {15'b0, w});
      capture(w, c, f_veff(v, c), cm, "rand");
      w2 = w;
    end
    reg_read(2'd0, d); chk("R2 final readback", d[NB-1:0], w2);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule